// File: doc/BRIEF.md
# Buffered Serial Transmitter with Break Generation

This block is the transmit half of an asynchronous serial port. Software works it through strobes: a control write, a data write, a status read and a strobe that clears the completion flag. A byte written while the line is quiet goes straight into the frame shifter. A byte written while a frame is on the line waits in a one-entry holding register and follows without a gap. Two status flags tell software what to do next. TXE means the holding register can take another byte. TC means the line has gone quiet with nothing left to send. An interrupt output follows TC when software enables it.

The control word also selects 8 or 9 data bits per frame and can request a break. A break is a run of low bit times with no stop level, followed by one forced high bit. The break waits behind the frame that is on the line and goes ahead of any byte in the holding register. The first byte written after the transmitter is enabled is preceded by one frame time of idle high level. Each bit lasts a fixed number of clock cycles, set by a parameter.

Top module: `sertx_core`

## Requirements
- R1: After reset, `tx_o` is 1, `txe_o` is 1, `tc_o` is 1, `brk_o` is 0 and `irq_o` is 0.
- R2: A data write is a direct load when the transmitter is enabled, the shifter is idle, the holding register is empty, no preamble is owed and no break is requested. A direct load drives the start bit (0) on `tx_o` from the next cycle, and `txe_o` stays 1.
- R3: A data write that cannot load directly goes into the holding register and clears `txe_o`. When the current frame ends, the held byte enters the shifter in the same cycle and `txe_o` returns to 1.
- R4: A data frame is one low start bit, then the data bits LSB first, then one high stop bit. Each bit lasts `CLKS_PER_BIT` cycles. There are `DATA_BITS` data bits, or one more when control bit 2 is 1. The length is latched when the frame starts.
- R5: `tc_o` is set only at the end of a frame after which the shifter goes idle. It stays 0 while a held byte follows the frame.
- R6: `irq_o` is 1 exactly while `tc_o` is 1 and control bit 1 (completion interrupt enable) is 1.
- R7: A status read while `tc_o` is 1, followed by a data write, clears `tc_o`. A data write with no such read first leaves `tc_o` unchanged. A pulse on `tc_clr_i` clears `tc_o`.
- R8: Control bit 0 enables the transmitter. A 0-to-1 change of this bit marks a preamble as owed. The next data write then starts with frame-length bit times of high level, and that byte sits in the holding register meanwhile.
- R9: Control bit 3 requests a break. The break starts once the current frame ends and goes ahead of a held byte. It is 10 low bit times, or 11 when control bit 2 is 1, followed by one high bit time.
- R10: Hardware clears control bit 3 (`brk_o`) when the low part of the break ends. If software writes the bit back to 0 before the break starts, no break is sent.
- R11: While control bit 0 is 0, `tx_o` is 1, data writes are ignored, and the holding register is emptied (`txe_o` = 1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctrl_wr_i | input | 1 | Control write strobe |
| ctrl_wdata_i | input | 4 | Control word: [0] enable, [1] completion irq enable, [2] long frame, [3] break request |
| data_wr_i | input | 1 | Data write strobe |
| data_i | input | DATA_BITS+1 | Data to send; the top bit is used only in long frames |
| stat_rd_i | input | 1 | Status read strobe (first step of the TC clear sequence) |
| tc_clr_i | input | 1 | Clears the completion flag directly |
| txe_o | output | 1 | Holding register empty |
| tc_o | output | 1 | Transmission complete |
| brk_o | output | 1 | Break request bit as currently held |
| irq_o | output | 1 | Completion interrupt |
| tx_o | output | 1 | Serial line, idles high |

## Verification
The hardest situation to reach is a frame boundary where three things compete at once: a break request, a byte in the holding register, and a possible completion flag. The stimulus starts a frame with a direct write. It then fills the holding register and sets the break bit, all within the first bit time. The monitor must then see the data frame, the break with its high tail, and the held byte in that order, with TC rising only after the last of them. A second sequence sets and then withdraws the break bit in the middle of a frame. Any break frame appearing on the line in that sequence counts as a miscompare.

// File: rtl/sertx_pkg.sv
package sertx_pkg;
   typedef enum logic [1:0] {FRM_PRE, FRM_DATA, FRM_BRK} frm_kind_t;
   localparam int CTL_EN   = 0;
   localparam int CTL_TCIE = 1;
   localparam int CTL_LONG = 2;
   localparam int CTL_BRK  = 3;
   localparam int CTL_W    = 4;
endpackage

// File: rtl/sertx_baud.sv
module sertx_baud #(
   parameter int CLKS_PER_BIT = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run_i,
   input  logic start_i,
   output logic bit_end_o
);
   generate
      if (CLKS_PER_BIT == 1) begin : g_single
         assign bit_end_o = run_i;
      end else begin : g_count
         localparam int CW = $clog2(CLKS_PER_BIT);
         logic [CW-1:0] cnt_q;
         assign bit_end_o = run_i && (cnt_q == CW'(CLKS_PER_BIT - 1));
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                     cnt_q <= '0;
            else if (start_i || !run_i)     cnt_q <= '0;
            else if (bit_end_o)             cnt_q <= '0;
            else                            cnt_q <= cnt_q + 1'b1;
         end
      end
   endgenerate
endmodule

// File: rtl/sertx_shift.sv
module sertx_shift
   import sertx_pkg::*;
#(
   parameter int DATA_BITS = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             abort_i,
   input  logic             start_i,
   input  frm_kind_t        kind_i,
   input  logic [DATA_BITS:0] data_i,
   input  logic             long_i,
   input  logic             bit_end_i,
   output logic             busy_o,
   output logic             frame_done_o,
   output logic             brk_low_done_o,
   output logic             tx_o
);
   localparam int FRM_W = DATA_BITS + 4;
   localparam int IW    = $clog2(FRM_W + 1);

   logic [FRM_W-1:0] sh_q, pat;
   logic [IW-1:0]    idx_q, last_q, last_n;
   frm_kind_t        kind_q;
   logic             busy_q;

   always_comb begin
      int nb;
      nb     = long_i ? DATA_BITS + 1 : DATA_BITS;
      pat    = '1;
      last_n = IW'(nb + 1);
      case (kind_i)
         FRM_DATA: begin
            pat[0] = 1'b0;
            for (int i = 0; i < DATA_BITS + 1; i++)
               if (i < nb) pat[i+1] = data_i[i];
         end
         FRM_BRK: begin
            for (int i = 0; i < FRM_W; i++)
               if (i < nb + 2) pat[i] = 1'b0;
            last_n = IW'(nb + 2);
         end
         default: ;
      endcase
   end

   assign busy_o         = busy_q;
   assign frame_done_o   = busy_q && bit_end_i && (idx_q == last_q);
   assign brk_low_done_o = busy_q && bit_end_i && (kind_q == FRM_BRK) &&
                           ((idx_q + IW'(1)) == last_q);
   assign tx_o           = busy_q ? sh_q[0] : 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         sh_q   <= '1;
         idx_q  <= '0;
         last_q <= '0;
         kind_q <= FRM_PRE;
      end else if (abort_i) begin
         busy_q <= 1'b0;
         sh_q   <= '1;
      end else if (start_i) begin
         busy_q <= 1'b1;
         sh_q   <= pat;
         idx_q  <= '0;
         last_q <= last_n;
         kind_q <= kind_i;
      end else if (frame_done_o) begin
         busy_q <= 1'b0;
      end else if (busy_q && bit_end_i) begin
         sh_q  <= {1'b1, sh_q[FRM_W-1:1]};
         idx_q <= idx_q + 1'b1;
      end
   end

   assert_brk_tail_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (brk_low_done_o && !abort_i && !start_i) |=> tx_o);
endmodule

// File: rtl/sertx_tcflag.sv
module sertx_tcflag (
   input  logic clk,
   input  logic rst_n,
   input  logic tc_set_i,
   input  logic stat_rd_i,
   input  logic data_wr_i,
   input  logic tc_clr_i,
   input  logic tcie_i,
   output logic tc_o,
   output logic irq_o
);
   logic tc_q, rd_seen_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tc_q      <= 1'b1;
         rd_seen_q <= 1'b0;
      end else if (tc_set_i) begin
         tc_q      <= 1'b1;
         rd_seen_q <= 1'b0;
      end else begin
         if (tc_clr_i || (data_wr_i && rd_seen_q)) tc_q <= 1'b0;
         if (data_wr_i)                 rd_seen_q <= 1'b0;
         else if (stat_rd_i && tc_q)    rd_seen_q <= 1'b1;
      end
   end

   assign tc_o  = tc_q;
   assign irq_o = tc_q && tcie_i;

   assert_tc_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (tc_clr_i && !tc_set_i) |=> !tc_o);
endmodule

// File: rtl/sertx_core.sv
module sertx_core
   import sertx_pkg::*;
#(
   parameter int CLKS_PER_BIT = 16,
   parameter int DATA_BITS    = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               ctrl_wr_i,
   input  logic [3:0]         ctrl_wdata_i,
   input  logic               data_wr_i,
   input  logic [DATA_BITS:0] data_i,
   input  logic               stat_rd_i,
   input  logic               tc_clr_i,
   output logic               txe_o,
   output logic               tc_o,
   output logic               brk_o,
   output logic               irq_o,
   output logic               tx_o
);
   generate
      if (CLKS_PER_BIT < 1) begin : g_bad_cpb
         $error("CLKS_PER_BIT must be at least 1");
      end
      if (DATA_BITS < 5 || DATA_BITS > 15) begin : g_bad_dw
         $error("DATA_BITS must lie in 5..15");
      end
   endgenerate

   logic en_q, tcie_q, long_q, brk_q, pend_pre_q;
   logic buf_full_q;
   logic [DATA_BITS:0] buf_q;

   logic busy, frame_done, brk_low_done, bit_end;
   logic dis_now, abort, wr_ok, free, start, from_buf, direct;
   frm_kind_t kind;
   logic [DATA_BITS:0] start_data;

   assign dis_now = ctrl_wr_i && !ctrl_wdata_i[CTL_EN];
   assign abort   = !en_q || dis_now;
   assign wr_ok   = data_wr_i && en_q && !dis_now;
   assign free    = en_q && !dis_now && (!busy || frame_done);

   always_comb begin
      start      = 1'b0;
      from_buf   = 1'b0;
      direct     = 1'b0;
      kind       = FRM_DATA;
      start_data = buf_q;
      if (free) begin
         if (brk_q) begin
            start = 1'b1;
            kind  = FRM_BRK;
         end else if (buf_full_q) begin
            start    = 1'b1;
            from_buf = 1'b1;
         end else if (wr_ok && pend_pre_q) begin
            start = 1'b1;
            kind  = FRM_PRE;
         end else if (wr_ok) begin
            start      = 1'b1;
            direct     = 1'b1;
            start_data = data_i;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q <= 1'b0; tcie_q <= 1'b0; long_q <= 1'b0; brk_q <= 1'b0;
         pend_pre_q <= 1'b0;
      end else begin
         if (ctrl_wr_i) begin
            en_q   <= ctrl_wdata_i[CTL_EN];
            tcie_q <= ctrl_wdata_i[CTL_TCIE];
            long_q <= ctrl_wdata_i[CTL_LONG];
            brk_q  <= ctrl_wdata_i[CTL_BRK];
         end else if (brk_low_done) begin
            brk_q  <= 1'b0;
         end
         if (dis_now)                                 pend_pre_q <= 1'b0;
         else if (ctrl_wr_i && !en_q)                 pend_pre_q <= 1'b1;
         else if (start && kind == FRM_PRE)           pend_pre_q <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         buf_full_q <= 1'b0;
         buf_q      <= '0;
      end else if (abort) begin
         buf_full_q <= 1'b0;
      end else if (wr_ok && !direct) begin
         buf_full_q <= 1'b1;
         buf_q      <= data_i;
      end else if (from_buf) begin
         buf_full_q <= 1'b0;
      end
   end

   sertx_baud #(.CLKS_PER_BIT(CLKS_PER_BIT)) baud_i (
      .clk(clk), .rst_n(rst_n), .run_i(busy), .start_i(start),
      .bit_end_o(bit_end));

   sertx_shift #(.DATA_BITS(DATA_BITS)) shift_i (
      .clk(clk), .rst_n(rst_n), .abort_i(abort), .start_i(start),
      .kind_i(kind), .data_i(start_data), .long_i(long_q),
      .bit_end_i(bit_end), .busy_o(busy), .frame_done_o(frame_done),
      .brk_low_done_o(brk_low_done), .tx_o(tx_o));

   sertx_tcflag tcflag_i (
      .clk(clk), .rst_n(rst_n), .tc_set_i(frame_done && !start),
      .stat_rd_i(stat_rd_i), .data_wr_i(data_wr_i), .tc_clr_i(tc_clr_i),
      .tcie_i(tcie_q), .tc_o(tc_o), .irq_o(irq_o));

   assign txe_o = !buf_full_q;
   assign brk_o = brk_q;

   assert_direct_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (data_wr_i && en_q && !ctrl_wr_i && !busy && !buf_full_q && !pend_pre_q && !brk_q)
      |=> (txe_o && !tx_o));
   assert_buffered_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (data_wr_i && en_q && !ctrl_wr_i && busy && !frame_done) |=> !txe_o);
   assert_tc_needs_empty_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tc_o) |-> txe_o);
   assert_brk_hw_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(brk_q) && !$past(ctrl_wr_i)) |-> $past(brk_low_done));
   assert_line_high_off_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !en_q |-> tx_o);
endmodule

// File: tb/sertx_core_tb_top.sv
module sertx_core_tb_top;
   localparam int CPB = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ctrl_wr = 1'b0, data_wr = 1'b0, stat_rd = 1'b0, tc_clr = 1'b0;
   logic [3:0] ctrl_wdata = '0;
   logic [8:0] data_in = '0;
   logic txe_o, tc_o, brk_o, irq_o, tx_o;

   always #10 clk = ~clk;

   sertx_core #(.CLKS_PER_BIT(CPB), .DATA_BITS(8)) dut_i (
      .clk(clk), .rst_n(rst_n), .ctrl_wr_i(ctrl_wr), .ctrl_wdata_i(ctrl_wdata),
      .data_wr_i(data_wr), .data_i(data_in), .stat_rd_i(stat_rd), .tc_clr_i(tc_clr),
      .txe_o(txe_o), .tc_o(tc_o), .brk_o(brk_o), .irq_o(irq_o), .tx_o(tx_o));

   typedef struct packed { logic brk; logic [8:0] data; } exp_t;
   exp_t exp_q[$];
   int n_vec = 0, n_bad = 0;
   logic mon_long = 1'b0;
   logic done = 1'b0;

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      n_vec++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %0h expected %0h", tag, got, exp);
      end
   endtask

   task automatic push_data(input logic [8:0] d);
      exp_t e;
      e.brk = 1'b0; e.data = mon_long ? d : {1'b0, d[7:0]};
      exp_q.push_back(e);
   endtask

   task automatic push_brk();
      exp_t e;
      e.brk = 1'b1; e.data = '0;
      exp_q.push_back(e);
   endtask

   task automatic wr_data(input logic [8:0] d);
      @(negedge clk); data_wr = 1'b1; data_in = d;
      @(negedge clk); data_wr = 1'b0;
   endtask

   task automatic wr_ctrl(input logic [3:0] v);
      @(negedge clk); ctrl_wr = 1'b1; ctrl_wdata = v;
      @(negedge clk); ctrl_wr = 1'b0;
   endtask

   task automatic rd_stat();
      @(negedge clk); stat_rd = 1'b1;
      @(negedge clk); stat_rd = 1'b0;
   endtask

   task automatic clr_tc();
      @(negedge clk); tc_clr = 1'b1;
      @(negedge clk); tc_clr = 1'b0;
   endtask

   task automatic wait_tc();
      while (!tc_o) @(negedge clk);
   endtask

   // monitor: rebuilds frames from the line, compares against the queue
   logic [8:0] m_d;
   logic m_stp, m_tail, m_brk;
   exp_t m_e;
   initial begin
      forever begin
         @(negedge clk);
         if (rst_n && !tx_o) begin
            m_d = '0; m_tail = 1'b1;
            repeat (CPB/2 - 1) @(negedge clk);
            for (int i = 0; i < (mon_long ? 9 : 8); i++) begin
               repeat (CPB) @(negedge clk);
               m_d[i] = tx_o;
            end
            repeat (CPB) @(negedge clk);
            m_stp = tx_o;
            m_brk = !m_stp && (m_d == '0);
            if (m_brk) begin
               repeat (CPB) @(negedge clk);
               m_tail = tx_o;
            end
            if (exp_q.size() == 0) begin
               chk("R9/R4 unexpected frame on line", {m_brk, m_d}, 32'hFFFF);
            end else begin
               m_e = exp_q.pop_front();
               if (m_e.brk) begin
                  chk("R9 break frame expected", {31'd0, m_brk}, 1);
                  chk("R9 high bit after break", {31'd0, m_tail}, 1);
               end else begin
                  chk("R4 data frame contents", {m_brk, m_d}, {1'b0, m_e.data});
                  chk("R4 stop bit", {31'd0, m_stp}, 1);
               end
            end
         end
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_vec++; n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      int lows;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 tx", tx_o, 1); chk("R1 txe", txe_o, 1); chk("R1 tc", tc_o, 1);
      chk("R1 irq", irq_o, 0); chk("R1 brk", brk_o, 0);

      // R8 preamble before first byte, R6 irq, R7 clear sequence
      wr_ctrl(4'b0011);
      chk("R6 irq with tc and enable", irq_o, 1);
      rd_stat();
      push_data(9'h0A5);
      wr_data(9'h0A5);
      chk("R7 tc cleared by read then write", tc_o, 0);
      chk("R6 irq follows tc", irq_o, 0);
      chk("R3 byte held during preamble", txe_o, 0);
      repeat (10*CPB - 1) @(negedge clk);
      chk("R8 line high through preamble", tx_o, 1);
      @(negedge clk);
      chk("R8 start bit right after preamble", tx_o, 0);
      chk("R3 held byte moved at frame end", txe_o, 1);
      wait_tc();
      chk("R6 irq on completion", irq_o, 1);

      // R2 direct load, R7 write without read
      wr_data(9'h03C);
      push_data(9'h03C);
      chk("R2 start bit next cycle", tx_o, 0);
      chk("R2 txe stays set", txe_o, 1);
      chk("R7 tc kept without status read", tc_o, 1);
      repeat (11*CPB) @(negedge clk);
      clr_tc();
      chk("R7 tc cleared by clear strobe", tc_o, 0);

      // R5 back to back
      push_data(9'h011); push_data(9'h022);
      wr_data(9'h011); wr_data(9'h022);
      chk("R3 second byte held", txe_o, 0);
      while (!txe_o) @(negedge clk);
      repeat (2) @(negedge clk);
      chk("R5 tc low while held byte follows", tc_o, 0);
      wait_tc();
      chk("R5 tc after last frame, txe", txe_o, 1);

      // long frames and long break
      wr_ctrl(4'b0111); mon_long = 1'b1;
      rd_stat();
      push_data(9'h1C3);
      wr_data(9'h1C3);
      chk("R7 tc cleared in long mode", tc_o, 0);
      wait_tc();
      push_brk();
      wr_ctrl(4'b1111);
      chk("R10 break bit held", brk_o, 1);
      while (brk_o) @(negedge clk);
      repeat (2*CPB) @(negedge clk);
      chk("R10 break bit cleared by hardware", brk_o, 0);
      wr_ctrl(4'b0011); mon_long = 1'b0;

      // R9 break queued behind frame and ahead of held byte
      clr_tc();
      push_data(9'h05A); push_brk(); push_data(9'h081);
      wr_data(9'h05A); wr_data(9'h081);
      wr_ctrl(4'b1011);
      chk("R3 held byte waits behind break", txe_o, 0);
      wait_tc();
      chk("R10 bit cleared after break", brk_o, 0);
      chk("R9 all frames seen", exp_q.size(), 0);

      // R10 break withdrawn before it starts
      clr_tc();
      push_data(9'h077);
      wr_data(9'h077);
      wr_ctrl(4'b1011);
      repeat (3) @(negedge clk);
      wr_ctrl(4'b0011);
      wait_tc();
      repeat (15*CPB) @(negedge clk);
      chk("R10 withdrawn break bit", brk_o, 0);
      chk("R10 no extra frame", exp_q.size(), 0);

      // R11 disabled
      wr_ctrl(4'b0010);
      chk("R11 line high when off", tx_o, 1);
      wr_data(9'h000);
      lows = 0;
      for (int i = 0; i < 12*CPB; i++) begin
         @(negedge clk);
         if (!tx_o) lows++;
      end
      chk("R11 write ignored, line quiet", lows, 0);
      chk("R11 txe set when off", txe_o, 1);
      chk("R4/R9 scoreboard drained", exp_q.size(), 0);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule